// File: doc/BRIEF.md
# Timed Pattern Output Controller

This block drives a 12-bit parallel output port from bit patterns that software loads in advance. Software places the coming pattern in a next-data buffer over a simple register bus. The port bits are split into three groups of four. Each group follows one of several timer compare-match strobes, and a bus register chooses that strobe. When the chosen strobe pulses, the buffered bits of that group are copied into the port data register. A per-bit enable decides which port bits take part in the copy.

Port bits that are not enabled act as an ordinary data register that software writes directly. The hardware standby input clears all enables. The software standby input freezes every register, so nothing moves until it is released.

Top module: `pattern_out_ctrl`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), every register and `port_out` read as zero.
- R2: Group g (port bits 4g+3..4g) fires in a cycle when `cm_trig[s]` is high, where s is the 2-bit field at bits 2g+1..2g of the trigger-select register.
- R3: When a group fires, each enabled bit of that group takes its next-data bit at the following edge.
- R4: When a group fires, a disabled bit of that group keeps its port value.
- R5: Groups transfer independently. A strobe that no group has selected changes nothing.
- R6: A next-data write in the same cycle as a firing group: the port takes the old buffered value, and the written value is stored for the next transfer.
- R7: A bus write to the port data register takes effect at the next edge. If an enabled bit's group fires in that same cycle, the next-data bit wins for that bit.
- R8: While `hw_stby` is high, both enable registers are cleared and writes to them are ignored. The other registers keep their contents.
- R9: While `sw_stby` is high and `hw_stby` is low, all registers and `port_out` hold. Strobes and bus writes are ignored.
- R10: Register map on `bus_addr`: 0 enable bits 7..0, 1 enable bits 11..8 in data bits 3..0, 2 next-data 7..0, 3 next-data 11..8 in bits 3..0, 4 port 7..0, 5 port 11..8 in bits 3..0, 6 trigger select in bits 5..0. Unused bits and address 7 read zero. Each register reads back its current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_stby | input | 1 | Hardware standby, clears enables |
| sw_stby | input | 1 | Software standby, freezes state |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| cm_trig | input | 4 | Compare-match strobes |
| port_out | output | 12 | Port data value |

## Verification
Two kinds of same-cycle collision are forced on purpose. In the first, a compare-match strobe lands in the same cycle as a write to the next-data register it copies from. In the second, a strobe lands in the same cycle as a direct write to the port register whose bits are only partly enabled. In each case the bench drives both inputs on one falling edge. A bench model then predicts the result: the old buffer value goes out, and enabled bits take buffered data while disabled bits take the written data. After that, a second strobe shows the newly written buffer value reaching the port.

// File: rtl/pattern_out_ctrl.sv
module pattern_out_ctrl #(
  parameter int GRP_W  = 4,
  parameter int N_GRP  = 3,
  parameter int N_TRIG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [N_TRIG-1:0] cm_trig,
  output logic [11:0]       port_out
);
  localparam int OUT_W = GRP_W * N_GRP;
  localparam int SEL_W = $clog2(N_TRIG);
  localparam int TS_W  = SEL_W * N_GRP;

  localparam logic [2:0] A_EN_LO = 3'd0, A_EN_HI = 3'd1, A_NX_LO = 3'd2,
                         A_NX_HI = 3'd3, A_PT_LO = 3'd4, A_PT_HI = 3'd5,
                         A_TSEL  = 3'd6;

  logic [OUT_W-1:0] en_q, nxt_q, port_q, fire_mask, xfer, port_wr;
  logic [TS_W-1:0]  tsel_q;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign fire_mask[g*GRP_W +: GRP_W] = {GRP_W{cm_trig[tsel_q[g*SEL_W +: SEL_W]]}};
  end

  assign xfer = fire_mask & en_q;

  always_comb begin
    port_wr = port_q;
    if (bus_we && bus_addr == A_PT_LO) port_wr[7:0]  = bus_wdata;
    if (bus_we && bus_addr == A_PT_HI) port_wr[11:8] = bus_wdata[3:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      nxt_q  <= '0;
      port_q <= '0;
      tsel_q <= '0;
    end else begin
      if (hw_stby) en_q <= '0;
      else if (!sw_stby && bus_we && bus_addr == A_EN_LO) en_q[7:0]  <= bus_wdata;
      else if (!sw_stby && bus_we && bus_addr == A_EN_HI) en_q[11:8] <= bus_wdata[3:0];
      if (!sw_stby) begin
        port_q <= (port_wr & ~xfer) | (nxt_q & xfer);
        if (bus_we && bus_addr == A_NX_LO) nxt_q[7:0]  <= bus_wdata;
        if (bus_we && bus_addr == A_NX_HI) nxt_q[11:8] <= bus_wdata[3:0];
        if (bus_we && bus_addr == A_TSEL)  tsel_q      <= bus_wdata[TS_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_EN_LO: bus_rdata      = en_q[7:0];
      A_EN_HI: bus_rdata[3:0] = en_q[11:8];
      A_NX_LO: bus_rdata      = nxt_q[7:0];
      A_NX_HI: bus_rdata[3:0] = nxt_q[11:8];
      A_PT_LO: bus_rdata      = port_q[7:0];
      A_PT_HI: bus_rdata[3:0] = port_q[11:8];
      A_TSEL:  bus_rdata[TS_W-1:0] = tsel_q;
      default: bus_rdata = '0;
    endcase
  end

  assign port_out = port_q;
endmodule

// File: rtl/pattern_out_ctrl_chk.sv
module pattern_out_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        hw_stby,
  input logic        sw_stby,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [3:0]  cm_trig,
  input logic [11:0] port_out,
  input logic [11:0] en,
  input logic [11:0] nxt,
  input logic [5:0]  tsel
);
  logic port_wr;
  assign port_wr = bus_we && (bus_addr == 3'd4 || bus_addr == 3'd5);

  // R8
  hw_clears_en_chk: assert property (@(posedge clk) disable iff (rst)
    hw_stby |=> en == 12'h000);

  // R9
  sw_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_stby && !hw_stby) |=> ($stable(port_out) && $stable(nxt) && $stable(tsel) && $stable(en)));

  // R4
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sw_stby && !port_wr) |=> (((port_out ^ $past(port_out)) & ~$past(en)) == 12'h000));

  for (genvar g = 0; g < 3; g++) begin : g_chk
    // R3
    enabled_copy_chk: assert property (@(posedge clk) disable iff (rst)
      (!sw_stby && cm_trig[tsel[2*g +: 2]]) |=>
        ((port_out[4*g +: 4] & $past(en[4*g +: 4])) == ($past(nxt[4*g +: 4]) & $past(en[4*g +: 4]))));
  end
endmodule

bind pattern_out_ctrl pattern_out_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .hw_stby(hw_stby), .sw_stby(sw_stby),
  .bus_we(bus_we), .bus_addr(bus_addr), .cm_trig(cm_trig),
  .port_out(port_out), .en(en_q), .nxt(nxt_q), .tsel(tsel_q)
);

// File: tb/pattern_out_ctrl_bench.sv
module pattern_out_ctrl_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hw_stby = 1'b0, sw_stby = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  cm_trig = '0;
  logic [11:0] port_out;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [11:0] m_en = '0, m_nxt = '0, m_port = '0;
  logic [5:0]  m_tsel = '0;

  logic [11:0] exp_q[$];
  string       req_q[$];

  always #(CLK_P/2) clk = ~clk;

  pattern_out_ctrl u_pattern_out_ctrl (
    .clk(clk), .rst(rst), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cm_trig(cm_trig), .port_out(port_out)
  );

  initial begin : monitor
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        logic [11:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        n_vec++;
        if (port_out !== e) begin
          n_bad++;
          $display("FAIL %s port_out actual=%h expected=%h", r, port_out, e);
        end
      end
    end
  end

  task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d,
                      input logic [3:0] t, input logic h, input logic s, input string req);
    logic [11:0] x, pw;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; cm_trig = t; hw_stby = h; sw_stby = s;
    x = '0;
    for (int g = 0; g < 3; g++)
      if (t[m_tsel[2*g +: 2]]) x[4*g +: 4] = 4'hF;
    x &= m_en;
    if (!s) begin
      pw = m_port;
      if (we && a == 3'd4) pw[7:0]  = d;
      if (we && a == 3'd5) pw[11:8] = d[3:0];
      m_port = (pw & ~x) | (m_nxt & x);
      if (we && a == 3'd2) m_nxt[7:0]  = d;
      if (we && a == 3'd3) m_nxt[11:8] = d[3:0];
      if (we && a == 3'd6) m_tsel = d[5:0];
      if (!h && we && a == 3'd0) m_en[7:0]  = d;
      if (!h && we && a == 3'd1) m_en[11:8] = d[3:0];
    end
    if (h) m_en = '0;
    exp_q.push_back(m_port);
    req_q.push_back(req);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string req);
    step(1'b1, a, d, 4'h0, 1'b0, 1'b0, req);
  endtask

  function automatic logic [7:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_en[7:0];
      3'd1: return {4'h0, m_en[11:8]};
      3'd2: return m_nxt[7:0];
      3'd3: return {4'h0, m_nxt[11:8]};
      3'd4: return m_port[7:0];
      3'd5: return {4'h0, m_port[11:8]};
      3'd6: return {2'b00, m_tsel};
      default: return 8'h00;
    endcase
  endfunction

  task automatic rd_all(input string req);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      bus_we = 0; cm_trig = 0; hw_stby = 0; sw_stby = 0; bus_addr = 3'(a);
      #1;
      n_vec++;
      if (bus_rdata !== model_rd(3'(a))) begin
        n_bad++;
        $display("FAIL %s addr %0d rdata actual=%h expected=%h", req, a, bus_rdata, model_rd(3'(a)));
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(CLK_P * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 0;
    rd_all("R1 reset");
    step(0, 0, 0, 4'h0, 0, 0, "R1 reset port");
    // group0<-trig0, group1<-trig1, group2<-trig2
    wr(3'd6, 8'h24, "R10 tsel write");
    wr(3'd0, 8'h0F, "R10 en lo write");
    wr(3'd1, 8'h0F, "R10 en hi write");
    wr(3'd2, 8'hA5, "R10 nxt lo write");
    wr(3'd3, 8'h03, "R10 nxt hi write");
    rd_all("R10 readback");
    step(0, 0, 0, 4'b0001, 0, 0, "R3 R5 group0 fires");
    step(0, 0, 0, 4'b0010, 0, 0, "R4 group1 disabled bits hold");
    wr(3'd0, 8'hFF, "R10 en lo all");
    step(0, 0, 0, 4'b0010, 0, 0, "R3 group1 fires");
    step(0, 0, 0, 4'b0100, 0, 0, "R2 group2 on trig2");
    step(0, 0, 0, 4'b1000, 0, 0, "R5 unselected strobe");
    // reselect: group0<-trig3, group1<-trig3, group2<-trig0
    wr(3'd6, 8'h0F, "R10 tsel rewrite");
    wr(3'd2, 8'h00, "R10 nxt lo clear");
    step(0, 0, 0, 4'b0001, 0, 0, "R2 group2 on trig0");
    step(0, 0, 0, 4'b1000, 0, 0, "R2 group0 group1 on trig3");
    wr(3'd6, 8'h24, "R10 tsel restore");
    wr(3'd2, 8'h96, "R10 nxt lo set");
    step(1, 3'd2, 8'h3C, 4'b0001, 0, 0, "R6 nxt write with fire");
    step(0, 0, 0, 4'b0001, 0, 0, "R6 new nxt reaches port");
    wr(3'd0, 8'h0F, "R10 en lo half");
    step(1, 3'd4, 8'hF0, 4'b0000, 0, 0, "R7 port write immediate");
    step(1, 3'd4, 8'h5A, 4'b0011, 0, 0, "R7 port write with fire");
    step(1, 3'd5, 8'h0E, 4'b0000, 0, 0, "R7 port hi write");
    step(1, 3'd2, 8'hFF, 4'b0111, 0, 1, "R9 sw standby freeze");
    step(1, 3'd0, 8'h00, 4'b0001, 0, 1, "R9 sw standby en write");
    rd_all("R9 state kept");
    step(1, 3'd2, 8'h77, 4'b0000, 1, 0, "R8 hw standby");
    step(1, 3'd0, 8'hFF, 4'b0111, 1, 0, "R8 en write ignored");
    rd_all("R8 readback");
    step(0, 0, 0, 4'b0111, 0, 0, "R4 all disabled after hw standby");
    @(negedge clk);
    rst = 1;
    m_en = '0; m_nxt = '0; m_port = '0; m_tsel = '0;
    @(negedge clk);
    rst = 0;
    rd_all("R1 second reset");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule